// File: doc/BRIEF.md
# Physics Trigger Decision Unit

This block makes the per-cycle trigger decision for a coincidence experiment. Each clock it looks at a summed calorimeter charge, two direction-match flags (one for a narrow and one for a wide acceptance window, both computed upstream), and a signed photon-to-positron time difference. From these it derives six trigger types: the main coincidence trigger, three debugging variants that each relax exactly one criterion of the main trigger, a single-detector charge trigger, and an internal pseudo-random trigger for baseline acquisition.

Each type has its own enable bit and its own 16-bit prescale factor. The surviving triggers are merged into one registered accept strobe, accompanied by a pattern word naming the types that fired and an event counter. Free-running per-type rate counters and live-time/dead-time counters, gated by a busy input from the acquisition system, support rate and efficiency bookkeeping. Threshold and window values arrive as static inputs; computing the charge, direction and time quantities is done elsewhere.

Top module: `trig_decision_unit`

## Requirements
- R1: The main trigger (pattern bit 0) fires when charge_sum > thr_high (strict), dir_narrow_hit is 1, and |time_diff| < win_narrow (strict; time_diff is two's complement).
- R2: The charge-debugging trigger (pattern bit 1) is the main trigger with charge_sum compared against thr_low instead of thr_high.
- R3: The direction-debugging trigger (pattern bit 2) is the main trigger with dir_wide_hit in place of dir_narrow_hit.
- R4: The time-debugging trigger (pattern bit 3) is the main trigger with |time_diff| < win_wide in place of the narrow window.
- R5: The single-detector trigger (pattern bit 4) fires when charge_sum exceeds thr_high if single_use_high is 1, or thr_low if it is 0, with no direction or time requirement.
- R6: A type whose type_enable bit is 0 never appears in trig_pattern and never causes accept.
- R7: With prescale factor N (bits [16*i+15:16*i] of prescale_flat for type i), a type passes on its Nth, 2Nth, ... enabled non-busy occurrence after reset; N=1 passes every occurrence; N=0 blocks the type.
- R8: While busy is 1, accept stays 0 and prescaler progress does not advance.
- R9: accept rises on the clock edge that samples a passing trigger and lasts one cycle per such cycle; on that edge trig_pattern takes the set of passing types and event_count increments by one; otherwise both hold.
- R10: Rate counter i (bits [24*i+23:24*i] of rate_count_flat) increments on every cycle where type i's condition is true, regardless of enable, prescale or busy.
- R11: Each clock edge out of reset increments dead_count if busy is 1, otherwise live_count.
- R12: The random trigger (pattern bit 5) fires on a pseudo-random subset of cycles, on average about one in 2^RND_BITS.
- R13: While rst_n is 0, accept, trig_pattern, event_count, all rate counters, live_count and dead_count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| charge_sum | input | QW | Summed calorimeter charge |
| dir_narrow_hit | input | 1 | Direction matches narrow window |
| dir_wide_hit | input | 1 | Direction matches wide window |
| time_diff | input | TW | Signed photon-positron time difference |
| thr_high | input | QW | High charge threshold |
| thr_low | input | QW | Low charge threshold |
| win_narrow | input | TW | Narrow time window (unsigned) |
| win_wide | input | TW | Wide time window (unsigned) |
| single_use_high | input | 1 | Single-detector trigger uses high threshold |
| type_enable | input | 6 | Per-type enable bits |
| prescale_flat | input | 6*PSW | Per-type prescale factors |
| busy | input | 1 | Acquisition busy |
| accept | output | 1 | Trigger accept strobe |
| trig_pattern | output | 6 | Types that fired at the last accept |
| event_count | output | ECW | Number of accepts |
| rate_count_flat | output | 6*RCW | Per-type condition counters |
| live_count | output | TCW | Non-busy cycles |
| dead_count | output | TCW | Busy cycles |

## Verification
Every cycle the assertions check that accept never follows a busy sample, that event_count and trig_pattern move only with accept, that accepted patterns contain no disabled or zero-factor type, that live and dead counts split each cycle exactly, and that the main condition implies the charge and time debugging conditions when thresholds and windows are ordered. Only the directed scenarios show the exact condition truth table at strict threshold and window boundaries including negative time differences, the Nth-occurrence placement of prescaled accepts, the freezing of prescaler progress during busy, and exact rate counter totals.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int NUM_TRIG    = 6;
  localparam int TRIG_MAIN   = 0;
  localparam int TRIG_CHG    = 1;
  localparam int TRIG_DIR    = 2;
  localparam int TRIG_TIME   = 3;
  localparam int TRIG_SINGLE = 4;
  localparam int TRIG_RANDOM = 5;
endpackage

// File: rtl/trig_cond_eval.sv
module trig_cond_eval
  import trig_pkg::*;
#(
  parameter int QW = 16,
  parameter int TW = 12
) (
  input  logic [QW-1:0]        charge_sum,
  input  logic                 dir_narrow_hit,
  input  logic                 dir_wide_hit,
  input  logic signed [TW-1:0] time_diff,
  input  logic [QW-1:0]        thr_high,
  input  logic [QW-1:0]        thr_low,
  input  logic [TW-1:0]        win_narrow,
  input  logic [TW-1:0]        win_wide,
  input  logic                 single_use_high,
  output logic [TRIG_RANDOM-1:0] phys_hit
);
  // magnitude of a two's complement value; most negative maps to 2^(TW-1)
  function automatic logic [TW-1:0] abs_mag(input logic signed [TW-1:0] v);
    logic [TW-1:0] u;
    u = v;
    return v[TW-1] ? (~u + 1'b1) : u;
  endfunction

  function automatic logic above(input logic [QW-1:0] q, input logic [QW-1:0] thr);
    return q > thr;
  endfunction

  logic [TW-1:0] mag;
  logic q_hi, q_lo, t_nar, t_wid;

  always_comb begin
    mag   = abs_mag(time_diff);
    q_hi  = above(charge_sum, thr_high);
    q_lo  = above(charge_sum, thr_low);
    t_nar = mag < win_narrow;
    t_wid = mag < win_wide;
    phys_hit[TRIG_MAIN]   = q_hi & dir_narrow_hit & t_nar;
    phys_hit[TRIG_CHG]    = q_lo & dir_narrow_hit & t_nar;
    phys_hit[TRIG_DIR]    = q_hi & dir_wide_hit   & t_nar;
    phys_hit[TRIG_TIME]   = q_hi & dir_narrow_hit & t_wid;
    phys_hit[TRIG_SINGLE] = single_use_high ? q_hi : q_lo;
  end
endmodule

// File: rtl/trig_prescaler.sv
module trig_prescaler #(
  parameter int PSW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           occur,
  input  logic [PSW-1:0] factor,
  output logic           pass
);
  logic [PSW-1:0] cnt_q;
  logic [PSW:0]   next_cnt;
  logic           active;

  always_comb begin
    next_cnt = {1'b0, cnt_q} + 1'b1;
    active   = occur && (factor != '0);
    pass     = active && (next_cnt >= {1'b0, factor});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (active) cnt_q <= pass ? '0 : next_cnt[PSW-1:0];
  end
endmodule

// File: rtl/trig_random_src.sv
module trig_random_src #(
  parameter int RND_BITS = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic fire
);
  localparam int LW = 16;
  localparam logic [LW-1:0] TAPS = 16'hB400;
  localparam logic [LW-1:0] SEED = 16'hACE1;

  logic [LW-1:0] lfsr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lfsr_q <= SEED;
    else if (lfsr_q[0]) lfsr_q <= (lfsr_q >> 1) ^ TAPS;
    else               lfsr_q <= lfsr_q >> 1;
  end

  assign fire = (lfsr_q[RND_BITS-1:0] == '0);
endmodule

// File: rtl/trig_decision_unit.sv
module trig_decision_unit
  import trig_pkg::*;
#(
  parameter int QW       = 16,
  parameter int TW       = 12,
  parameter int PSW      = 16,
  parameter int RCW      = 24,
  parameter int ECW      = 32,
  parameter int TCW      = 32,
  parameter int RND_BITS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [QW-1:0]           charge_sum,
  input  logic                    dir_narrow_hit,
  input  logic                    dir_wide_hit,
  input  logic signed [TW-1:0]    time_diff,
  input  logic [QW-1:0]           thr_high,
  input  logic [QW-1:0]           thr_low,
  input  logic [TW-1:0]           win_narrow,
  input  logic [TW-1:0]           win_wide,
  input  logic                    single_use_high,
  input  logic [NUM_TRIG-1:0]     type_enable,
  input  logic [NUM_TRIG*PSW-1:0] prescale_flat,
  input  logic                    busy,
  output logic                    accept,
  output logic [NUM_TRIG-1:0]     trig_pattern,
  output logic [ECW-1:0]          event_count,
  output logic [NUM_TRIG*RCW-1:0] rate_count_flat,
  output logic [TCW-1:0]          live_count,
  output logic [TCW-1:0]          dead_count
);
  localparam int NT = NUM_TRIG;

  logic [TRIG_RANDOM-1:0] phys_hit;
  logic                   rnd_fire;
  logic [NT-1:0]          cond_raw;   // condition per type, before gating
  logic [NT-1:0]          occur;      // enabled, non-busy occurrences
  logic [NT-1:0]          passed;     // occurrences surviving the prescaler
  logic [NT-1:0]          ps_pass;

  trig_cond_eval #(.QW(QW), .TW(TW)) cond_i (
    .charge_sum     (charge_sum),
    .dir_narrow_hit (dir_narrow_hit),
    .dir_wide_hit   (dir_wide_hit),
    .time_diff      (time_diff),
    .thr_high       (thr_high),
    .thr_low        (thr_low),
    .win_narrow     (win_narrow),
    .win_wide       (win_wide),
    .single_use_high(single_use_high),
    .phys_hit       (phys_hit)
  );

  trig_random_src #(.RND_BITS(RND_BITS)) rnd_i (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (rnd_fire)
  );

  assign cond_raw = {rnd_fire, phys_hit};
  assign occur    = cond_raw & type_enable & {NT{~busy}};
  assign passed   = occur & ps_pass;

  for (genvar i = 0; i < NT; i++) begin : g_type
    logic [RCW-1:0] rate_q;

    trig_prescaler #(.PSW(PSW)) ps_i (
      .clk   (clk),
      .rst_n (rst_n),
      .occur (occur[i]),
      .factor(prescale_flat[i*PSW +: PSW]),
      .pass  (ps_pass[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rate_q <= '0;
      else if (cond_raw[i]) rate_q <= rate_q + 1'b1;
    end

    assign rate_count_flat[i*RCW +: RCW] = rate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept       <= 1'b0;
      trig_pattern <= '0;
      event_count  <= '0;
    end else begin
      accept <= |passed;
      if (|passed) begin
        trig_pattern <= passed;
        event_count  <= event_count + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_count <= '0;
      dead_count <= '0;
    end else if (busy) begin
      dead_count <= dead_count + 1'b1;
    end else begin
      live_count <= live_count + 1'b1;
    end
  end
endmodule

// File: rtl/trig_decision_checker.sv
module trig_decision_checker
  import trig_pkg::*;
#(
  parameter int QW  = 16,
  parameter int TW  = 12,
  parameter int PSW = 16,
  parameter int ECW = 32,
  parameter int TCW = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    busy,
  input logic [NUM_TRIG-1:0]     type_enable,
  input logic [NUM_TRIG*PSW-1:0] prescale_flat,
  input logic [QW-1:0]           thr_high,
  input logic [QW-1:0]           thr_low,
  input logic [TW-1:0]           win_narrow,
  input logic [TW-1:0]           win_wide,
  input logic [NUM_TRIG-1:0]     cond_raw,
  input logic                    accept,
  input logic [NUM_TRIG-1:0]     trig_pattern,
  input logic [ECW-1:0]          event_count,
  input logic [TCW-1:0]          live_count,
  input logic [TCW-1:0]          dead_count
);
  logic pv;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= 1'b0;
    else        pv <= 1'b1;
  end

  a_r8_no_accept_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pv && $past(busy) |-> !accept);

  a_r11_dead_step: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> (dead_count - $past(dead_count)) == {{(TCW-1){1'b0}}, $past(busy)});

  a_r11_live_step: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> (live_count - $past(live_count)) == {{(TCW-1){1'b0}}, !$past(busy)});

  a_r9_event_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    pv && accept |-> event_count == $past(event_count) + 1'b1);

  a_r9_event_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pv && !accept |-> event_count == $past(event_count));

  a_r9_pattern_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $countones(trig_pattern) > 0);

  a_r9_pattern_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pv && !accept |-> $stable(trig_pattern));

  a_r6_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    pv && accept |-> (trig_pattern & ~$past(type_enable)) == '0);

  a_r2_main_implies_chg: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_low <= thr_high) && cond_raw[TRIG_MAIN] |-> cond_raw[TRIG_CHG]);

  a_r4_main_implies_time: assert property (@(posedge clk) disable iff (!rst_n)
    (win_narrow <= win_wide) && cond_raw[TRIG_MAIN] |-> cond_raw[TRIG_TIME]);

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_zero
    a_r7_zero_factor_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      pv && accept && ($past(prescale_flat[i*PSW +: PSW]) == '0) |-> !trig_pattern[i]);
  end
endmodule

bind trig_decision_unit trig_decision_checker #(
  .QW(QW), .TW(TW), .PSW(PSW), .ECW(ECW), .TCW(TCW)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .type_enable  (type_enable),
  .prescale_flat(prescale_flat),
  .thr_high     (thr_high),
  .thr_low      (thr_low),
  .win_narrow   (win_narrow),
  .win_wide     (win_wide),
  .cond_raw     (cond_raw),
  .accept       (accept),
  .trig_pattern (trig_pattern),
  .event_count  (event_count),
  .live_count   (live_count),
  .dead_count   (dead_count)
);

// File: tb/trig_decision_unit_tb_top.sv
`timescale 1ns/1ps
module trig_decision_unit_tb_top;
  localparam int QW = 16, TW = 12, PSW = 16, RCW = 24, ECW = 32, TCW = 32, NT = 6;
  localparam int QH = 1000, QL = 500, WN = 10, WW = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic [QW-1:0] charge_sum;
  logic dir_narrow_hit, dir_wide_hit;
  logic signed [TW-1:0] time_diff;
  logic [QW-1:0] thr_high, thr_low;
  logic [TW-1:0] win_narrow, win_wide;
  logic single_use_high;
  logic [NT-1:0] type_enable;
  logic [NT*PSW-1:0] prescale_flat;
  logic busy;
  logic accept;
  logic [NT-1:0] trig_pattern;
  logic [ECW-1:0] event_count;
  logic [NT*RCW-1:0] rate_count_flat;
  logic [TCW-1:0] live_count, dead_count;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trig_decision_unit dut_i (
    .clk(clk), .rst_n(rst_n), .charge_sum(charge_sum),
    .dir_narrow_hit(dir_narrow_hit), .dir_wide_hit(dir_wide_hit),
    .time_diff(time_diff), .thr_high(thr_high), .thr_low(thr_low),
    .win_narrow(win_narrow), .win_wide(win_wide),
    .single_use_high(single_use_high), .type_enable(type_enable),
    .prescale_flat(prescale_flat), .busy(busy), .accept(accept),
    .trig_pattern(trig_pattern), .event_count(event_count),
    .rate_count_flat(rate_count_flat), .live_count(live_count),
    .dead_count(dead_count)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected physics conditions, bits 0..4
  function automatic logic [4:0] exp_phys(int q, bit dn, bit dw, int dt, bit selh);
    int mag;
    bit hi, lo, tn, tw;
    mag = (dt < 0) ? -dt : dt;
    hi = q > QH; lo = q > QL; tn = mag < WN; tw = mag < WW;
    return {selh ? hi : lo, hi && dn && tw, hi && dw && tn, lo && dn && tn, hi && dn && tn};
  endfunction

  function automatic logic [RCW-1:0] rate_of(int i);
    return rate_count_flat[i*RCW +: RCW];
  endfunction

  task automatic set_factor(input int i, input int f);
    prescale_flat[i*PSW +: PSW] = f[PSW-1:0];
  endtask

  task automatic cyc(input int q, input bit dn, input bit dw, input int dt, input bit b);
    @(negedge clk);
    charge_sum = q[QW-1:0]; dir_narrow_hit = dn; dir_wide_hit = dw;
    time_diff = dt[TW-1:0]; busy = b;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; charge_sum = '0; dir_narrow_hit = 0; dir_wide_hit = 0;
    time_diff = '0; busy = 0;
    repeat (2) @(negedge clk);
    // R13: everything zero while reset is held
    check("R13 accept in reset", accept, 0);
    check("R13 pattern in reset", trig_pattern, 0);
    check("R13 events in reset", event_count, 0);
    check("R13 rates in reset", rate_count_flat != 0, 0);
    check("R13 live in reset", live_count, 0);
    check("R13 dead in reset", dead_count, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_coinc();
    int qs[9] = '{1200, 700, 1200, 1200, 1000, 1200, 1200, 501, 1200};
    bit dns[9] = '{1, 1, 0, 1, 1, 1, 1, 1, 1};
    bit dws[9] = '{1, 1, 1, 1, 1, 1, 1, 0, 1};
    int dts[9] = '{-5, 3, 3, -25, 0, 10, -10, 9, -40};
    logic [63:0] ev;
    logic [NT-1:0] prev;
    type_enable = 6'h1F; single_use_high = 1;
    for (int i = 0; i < NT; i++) set_factor(i, 1);
    ev = event_count;
    for (int k = 0; k < 9; k++) begin
      logic [4:0] e;
      prev = trig_pattern;
      e = exp_phys(qs[k], dns[k], dws[k], dts[k], 1);
      cyc(qs[k], dns[k], dws[k], dts[k], 0);
      if (e != 0) begin
        ev++;
        check("R9 accept on hit", accept, 1);
        check("R1 main bit", trig_pattern[0], e[0]);
        check("R2 charge-debug bit", trig_pattern[1], e[1]);
        check("R3 direction-debug bit", trig_pattern[2], e[2]);
        check("R4 time-debug bit", trig_pattern[3], e[3]);
        check("R5 single bit", trig_pattern[4], e[4]);
      end else begin
        check("R9 no accept", accept, 0);
        check("R9 pattern held", trig_pattern, prev);
      end
      check("R9 event count", event_count, ev);
    end
    cyc(0, 0, 0, 0, 0);
    check("R9 accept one cycle", accept, 0);
  endtask

  task automatic t_single();
    type_enable = 6'h1F; single_use_high = 0;
    cyc(700, 0, 0, 100, 0);
    check("R5 single low threshold accept", accept, 1);
    check("R5 single low threshold pattern", trig_pattern, 6'h10);
    single_use_high = 1;
    cyc(700, 0, 0, 100, 0);
    check("R5 single high threshold blocks", accept, 0);
    cyc(1001, 0, 0, -2048, 0);
    check("R5 single high just above", trig_pattern, 6'h10);
    check("R5 single high accept", accept, 1);
  endtask

  task automatic t_mask();
    logic [63:0] ev;
    type_enable = 6'h1E; single_use_high = 1;
    cyc(1200, 1, 1, -5, 0);
    check("R6 main masked pattern", trig_pattern, 6'h1E);
    type_enable = 6'h00;
    ev = event_count;
    cyc(1200, 1, 1, -5, 0);
    check("R6 all masked accept", accept, 0);
    check("R6 all masked events", event_count, ev);
    check("R6 all masked pattern held", trig_pattern, 6'h1E);
  endtask

  task automatic run_prescale(input int f, input string tag);
    bit qs[10] = '{1, 0, 1, 1, 1, 0, 1, 1, 1, 1};
    int cnt = 0;
    int acc = 0;
    int eacc = 0;
    do_reset();
    type_enable = 6'h01; set_factor(0, f);
    for (int k = 0; k < 10; k++) begin
      bit e = 0;
      if (qs[k] && f != 0) begin
        cnt++;
        if (cnt == f) begin e = 1; cnt = 0; end
      end
      if (qs[k]) cyc(1200, 1, 0, 0, 0); else cyc(0, 0, 0, 0, 0);
      check(tag, accept, e);
      acc += accept; eacc += e;
    end
    check({tag, " total"}, acc, eacc);
  endtask

  task automatic t_prescale();
    run_prescale(3, "R7 prescale 3");
    run_prescale(1, "R7 prescale 1");
    run_prescale(0, "R7 prescale 0 blocks");
    set_factor(0, 1);
  endtask

  task automatic t_busy();
    logic [63:0] d0;
    do_reset();
    type_enable = 6'h01; set_factor(0, 2);
    d0 = dead_count;
    for (int k = 0; k < 3; k++) begin
      cyc(1200, 1, 0, 0, 1);
      check("R8 no accept while busy", accept, 0);
    end
    check("R11 dead count busy", dead_count - d0, 3);
    cyc(1200, 1, 0, 0, 0);
    check("R8 first live occurrence held back", accept, 0);
    cyc(1200, 1, 0, 0, 0);
    check("R8 second live occurrence passes", accept, 1);
    set_factor(0, 1);
  endtask

  task automatic t_rate();
    do_reset();
    type_enable = 6'h00; single_use_high = 1;
    for (int k = 0; k < 4; k++) cyc(1200, 1, 1, 0, 0);
    for (int k = 0; k < 2; k++) cyc(0, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) cyc(1200, 1, 1, 0, 1);
    cyc(700, 1, 0, 0, 0);
    check("R10 rate main", rate_of(0), 7);
    check("R10 rate charge-debug", rate_of(1), 8);
    check("R10 rate time-debug", rate_of(3), 7);
    check("R10 rate single", rate_of(4), 7);
    check("R10 no accept while masked", event_count, 0);
  endtask

  task automatic t_live();
    logic [63:0] l0, d0;
    l0 = live_count; d0 = dead_count;
    for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0, 1);
    for (int k = 0; k < 7; k++) cyc(0, 0, 0, 0, 0);
    check("R11 dead delta", dead_count - d0, 5);
    check("R11 live delta", live_count - l0, 7);
  endtask

  task automatic t_random();
    int acc = 0;
    int bad = 0;
    do_reset();
    type_enable = 6'h20; set_factor(5, 1);
    for (int k = 0; k < 400; k++) begin
      cyc(0, 0, 0, 0, 0);
      if (accept) begin
        acc++;
        if (trig_pattern != 6'h20) bad++;
      end
    end
    check("R12 random fires", acc > 5, 1);
    check("R12 random below every cycle", acc < 200, 1);
    check("R12 random pattern bit 5 only", bad, 0);
    check("R12 random rate matches accepts", rate_of(5), acc);
    check("R12 events match accepts", event_count, acc);
  endtask

  initial begin
    rst_n = 1'b0; charge_sum = '0; dir_narrow_hit = 0; dir_wide_hit = 0;
    time_diff = '0; busy = 0; single_use_high = 1; type_enable = '0;
    thr_high = QH; thr_low = QL; win_narrow = WN; win_wide = WW;
    prescale_flat = '0;
    for (int i = 0; i < NT; i++) set_factor(i, 1);
    do_reset();
    t_coinc();
    t_single();
    t_mask();
    t_prescale();
    t_busy();
    t_rate();
    t_live();
    t_random();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule